// File: doc/BRIEF.md
# Skewed-Carry Pipelined Pulse Counter

This block counts clock-synchronous pulses with a chain of divide-by-two stages, one for each output bit. A stage does not pass its carry on through combinational logic. When a stage's bit wraps from 1 to 0, the stage registers a carry flag for exactly one cycle, and the next stage toggles in that cycle. Each flip-flop therefore sees only one gate in front of it: an XOR, which acts as a 2:1 MUX between the bit and its inverse, or an AND. This keeps wide counters fast on fabrics that have no dedicated carry hardware.

The cost is a skewed output word. Bit k shows the count as it stood k cycles earlier. The raw word is therefore not a monotonic binary count while pulses are arriving. When the input has been idle long enough, the raw word equals the plain binary count. While pulses arrive on every cycle, the package function `psc_decode` recovers the binary count from the raw word. Turning the raw word into binary is left to the consumer, for example a separate decoding stage or software.

Top module: `pulse_skew_cnt`

## Requirements
- R1: The counter has W stages, with W a parameter of 2 or more and a default of 32. Output `raw_q[k]` is the bit of stage k. Once settled, the word wraps modulo 2^W, so 2^W+3 pulses read back as 3.
- R2: Stage 0 toggles at every clock edge where `cnt_en` is 1, including on consecutive cycles. It holds its value at every edge where `cnt_en` is 0.
- R3: Stage k (k < W-1) sets its carry flag at the edge where its bit falls from 1 to 0, and only then. The flag is high for exactly one cycle.
- R4: Stage k+1 toggles at exactly the edges where the carry flag of stage k is high. As a result, after any edge t, `raw_q[k]` equals bit k of the number of pulses accepted up to edge t-k.
- R5: A synchronous reset (`rst` = 1 at a clock edge) clears every stage bit and every carry flag to 0.
- R6: After W-1 or more consecutive edges with `cnt_en` = 0, `raw_q` equals the number of accepted pulses modulo 2^W.
- R7: After W-1 or more consecutive edges with `cnt_en` = 1 since reset or since the last idle edge, `psc_decode(raw_q, W)` equals the count modulo 2^W. For k = 1 to W-1 in increasing order, the function inverts bit k when the value of the lower k bits is less than k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count one pulse at this edge when 1 |
| raw_q | output | W | Skewed raw counter word; bit k lags by k cycles |

## Verification
On every cycle, the assertions check the local stage rules: stage 0 follows the enable, each carry flag rises exactly when its bit falls and lasts one cycle, each higher bit toggles exactly when the carry below it is present, and reset clears all state. The end-to-end meaning of the word can only be shown by the bench's scenarios. These include the k-cycle lag of each bit against a history of the pulse count, equality with the binary count after the word settles, wraparound, and the decode under continuous counting, which the bench also checks against an independent brute-force inverse.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Next value of a stage bit: XOR acts as a 2:1 mux of q and ~q.
  function automatic logic toggle_next(input logic q, input logic tgl);
    return q ^ tgl;
  endfunction

  // Carry flag: set for one cycle when a set bit is toggled (falls to 0).
  function automatic logic carry_next(input logic q, input logic tgl);
    return q & tgl;
  endfunction

  // Recover the binary count from the skewed raw word under continuous counting.
  // Bit k shows (count - k); it differs from the true bit k exactly when the
  // already corrected lower k bits hold a value below k.
  function automatic logic [63:0] psc_decode(input logic [63:0] raw, input int unsigned width);
    logic [63:0] y;
    logic [63:0] mask;
    y = raw;
    for (int k = 1; k < 64; k++) begin
      if (k < width) begin
        mask = (64'd1 << k) - 64'd1;
        if ((y & mask) < 64'(k)) y[k] = ~y[k];
      end
    end
    return y;
  endfunction

endpackage

// File: rtl/psc_toggle_bit.sv
module psc_toggle_bit (
  input  logic clk,
  input  logic rst,
  input  logic tgl,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= psc_pkg::toggle_next(q, tgl);
  end
endmodule

// File: rtl/psc_carry_flop.sv
module psc_carry_flop (
  input  logic clk,
  input  logic rst,
  input  logic bit_q,
  input  logic tgl,
  output logic cy
);
  always_ff @(posedge clk) begin
    if (rst) cy <= 1'b0;
    else     cy <= psc_pkg::carry_next(bit_q, tgl);
  end
endmodule

// File: rtl/psc_stage.sv
module psc_stage #(
  parameter bit HAS_CARRY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl,
  output logic q,
  output logic cy
);
  psc_toggle_bit u_bit (
    .clk (clk),
    .rst (rst),
    .tgl (tgl),
    .q   (q)
  );

  generate
    if (HAS_CARRY) begin : g_carry
      psc_carry_flop u_cy (
        .clk   (clk),
        .rst   (rst),
        .bit_q (q),
        .tgl   (tgl),
        .cy    (cy)
      );
    end else begin : g_nocarry
      assign cy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pulse_skew_cnt.sv
module pulse_skew_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  output logic [W-1:0] raw_q
);
  localparam int LAST = W - 1;

  // Named internal events: toggle strobe into each stage, carry flag out of each.
  logic [W-1:0] tgl_w;
  logic [W-1:0] carry_q;

  assign tgl_w[0] = cnt_en;

  generate
    for (genvar k = 0; k < W; k++) begin : g_stage
      if (k > 0) begin : g_link
        assign tgl_w[k] = carry_q[k-1];
      end
      psc_stage #(.HAS_CARRY(k != LAST)) u_stage (
        .clk (clk),
        .rst (rst),
        .tgl (tgl_w[k]),
        .q   (raw_q[k]),
        .cy  (carry_q[k])
      );
    end
  endgenerate
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [W-1:0] raw_q,
  input logic [W-1:0] carry_q
);
  // R2
  stage0_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (raw_q[0] != $past(raw_q[0])));
  // R2
  stage0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(raw_q[0]));

  generate
    for (genvar k = 0; k < W - 1; k++) begin : g_chk
      // R3
      carry_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(raw_q[k]) |-> carry_q[k]);
      // R3
      carry_only_fall_chk: assert property (@(posedge clk) disable iff (rst)
        carry_q[k] |-> $fell(raw_q[k]));
      // R3
      carry_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        carry_q[k] |=> !carry_q[k]);
      // R4
      next_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        carry_q[k] |=> (raw_q[k+1] != $past(raw_q[k+1])));
      // R4
      next_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_q[k] |=> $stable(raw_q[k+1]));
    end
  endgenerate

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (raw_q == '0 && carry_q == '0));
endmodule

bind pulse_skew_cnt psc_chk #(.W(W)) u_psc_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt_en  (cnt_en),
  .raw_q   (raw_q),
  .carry_q (carry_q)
);

// File: tb/pulse_skew_cnt_bench.sv
`timescale 1ns/1ps
module pulse_skew_cnt_bench;
  localparam int W = 6;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [W-1:0] raw_q;

  pulse_skew_cnt #(.W(W)) u_pulse_skew_cnt (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .raw_q  (raw_q)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] hist [W];   // hist[k]: pulse count after the edge k edges ago
  logic [W-1:0] cnt;
  int run_on;
  int run_off;

  function automatic logic [W-1:0] lag_expect();
    logic [W-1:0] e;
    for (int k = 0; k < W; k++) e[k] = hist[k][k];
    return e;
  endfunction

  // Independent inverse: search the count whose skewed image is the raw word.
  function automatic logic [W-1:0] brute_decode(input logic [W-1:0] r);
    logic [W-1:0] enc;
    logic [W-1:0] d;
    for (int v = 0; v < MOD; v++) begin
      for (int k = 0; k < W; k++) begin
        d = W'(v) - W'(k);
        enc[k] = d[k];
      end
      if (enc == r) return W'(v);
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < W; k++) hist[k] = '0;
    cnt = '0;
    run_on = 0;
    run_off = W;
  endtask

  // Sample at the falling edge, then drive the input for the next rising edge.
  task automatic step(input logic en);
    logic [63:0] dec;
    @(negedge clk);
    check(raw_q == lag_expect(), "R4 lag", 64'(raw_q), 64'(lag_expect()));
    if (run_off >= W - 1)
      check(raw_q == cnt, "R6 settled", 64'(raw_q), 64'(cnt));
    if (run_on >= W - 1) begin
      dec = psc_pkg::psc_decode(64'(raw_q), W);
      check(dec[W-1:0] == cnt, "R7 decode", dec, 64'(cnt));
      check(brute_decode(raw_q) == cnt, "R7 inverse", 64'(brute_decode(raw_q)), 64'(cnt));
    end
    cnt_en = en;
    if (en) cnt = cnt + 1'b1;
    for (int k = W - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = cnt;
    run_on  = en ? run_on + 1 : 0;
    run_off = en ? 0 : run_off + 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cnt_en = 1'b0;
    repeat (2) @(negedge clk);
    // R5: all state cleared by the synchronous reset
    check(raw_q == '0, "R5 reset", 64'(raw_q), 64'd0);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    do_reset();

    // R2: a single pulse then idle
    step(1'b1);
    repeat (W) step(1'b0);
    check(raw_q == W'(1), "R2 single pulse", 64'(raw_q), 64'd1);

    // R7: continuous counting across several wraps
    repeat (3 * MOD) step(1'b1);
    repeat (W) step(1'b0);

    // R1: wrap modulo 2^W after reset and 2^W+3 pulses
    do_reset();
    repeat (MOD + 3) step(1'b1);
    repeat (W) step(1'b0);
    check(raw_q == W'(3), "R1 wrap", 64'(raw_q), 64'd3);

    // R2: alternating enable pattern
    for (int i = 0; i < 200; i++) step(i[0]);

    // Random densities
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 800; i++) begin
        int unsigned pct;
        pct = (p == 0) ? 10 : (p == 1) ? 50 : 90;
        step(($urandom % 100) < pct);
      end
      repeat (W) step(1'b0);
    end

    // R5: reset in the middle of a burst, carries in flight
    repeat (MOD + W) step(1'b1);
    do_reset();
    repeat (W) step(1'b0);
    check(raw_q == '0, "R5 after burst", 64'(raw_q), 64'd0);

    // R3/R4: bursts shaped to end exactly at wrap points
    repeat (MOD - 1) step(1'b1);
    step(1'b0);
    step(1'b1);
    repeat (2 * W) step(1'b0);
    check(raw_q == '0, "R3 wrap carry", 64'(raw_q), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule